// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block produces the SCL and SDA line waveforms of an I2C master at the level of single bus events. A controller above it issues one command at a time: open the bus with a start condition, write one bit, read one bit, issue a repeated start, or close the bus with a stop. The block drives both lines in open-drain style. It reports a one-cycle completion strobe for each command, the last bit read, and whether it holds the bus.

Every phase length is a fixed count of base ticks. The count depends on one of three speed classes and on a slow-down code that stretches the high and low phases by roughly 0, 10, 20 or 30 %. A base tick lasts 1, 2 or 4 clock cycles. Each SCL low phase has two parts. First comes a data-hold slot in which SDA keeps its previous level. Then comes a data-setup slot in which SDA carries the new level. The two slots together fill exactly the low time. Speed, slow-down and tick selection are captured when a command is accepted and stay fixed until that command completes.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset neither line is pulled low, `bus_busy`, `cmd_done` and `rd_bit` are 0, and the block waits for a start.
- R2: An accepted start (`cmd_op`=0) pulls SDA low with SCL released for the high count H. `bus_busy` rises in the same cycle as SDA falls. After H, SCL is pulled low and `cmd_done` pulses.
- R3: While the bus is not held, commands other than start are ignored. While it is held, a start is ignored, as are op codes 5 to 7. An ignored command changes no output.
- R4: A write (`cmd_op`=3) keeps SDA unchanged for the hold count D with SCL low. It then sets SDA (pulled low when `cmd_wbit` is 0) for L−D ticks, releases SCL for H ticks, pulls SCL low and pulses `cmd_done`. SDA does not move while SCL is released.
- R5: A read (`cmd_op`=4) releases SDA after the hold count and follows the write timing. `rd_bit` takes the value `sda_in` had at the end of the SCL high phase.
- R6: A repeated start (`cmd_op`=1) releases SDA after D and waits L−D ticks. It then releases SCL for L ticks with SDA high and pulls SDA low for H ticks. After that it pulls SCL low and pulses `cmd_done`.
- R7: A stop (`cmd_op`=2) pulls SDA low after D and waits L−D ticks. It then releases SCL for H ticks and releases SDA for the bus-free time of L ticks. After that `bus_busy` clears and `cmd_done` pulses in the same cycle.
- R8: Counts per speed class (`speed_mode` 00 standard, 01 fast, 10/11 fastest), listed for slow-down codes 0..3. H is 108/120/132/144, 24/27/30/33 and 10/11/13/14. L is 132/144/156/168, 36/39/42/45 and 14/15/16/17. D is 24, 12 and 4.
- R9: `slow_code` 00, 01, 10 and 11 select the four columns of R8, so the bit period H+L grows to the values listed there.
- R10: A tick lasts m clocks: `tick_sel` 00 gives m=1, 01 gives m=2, and 10/11 gives m=4. In fast and fastest mode a selection of 4 is clamped to 2. Every phase lasts count×m clocks.
- R11: Changing `speed_mode`, `slow_code` or `tick_sel` while a command runs has no effect on that command.
- R12: `cmd_done` is high for exactly one cycle per accepted command. A command offered while another is running is ignored. A new command may be offered in the cycle `cmd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_mode | input | 2 | Speed class: 00 standard, 01 fast, 10/11 fastest |
| slow_code | input | 2 | Slow-down column 0..3 |
| tick_sel | input | 2 | Base tick length: 1, 2 or 4 clocks |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | 0 start, 1 repeated start, 2 stop, 3 write, 4 read |
| cmd_wbit | input | 1 | Bit value for a write |
| sda_in | input | 1 | Sensed SDA line level |
| cmd_done | output | 1 | One-cycle completion strobe |
| rd_bit | output | 1 | Bit captured by the last read |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| bus_busy | output | 1 | Bus held by this master |

## Verification
Two events share a cycle when a command ends and the next is offered at once. The bench always presents the next command in the cycle where `cmd_done` is high, so acceptance in the waiting state meets the strobe of the previous command. The bench also changes the speed inputs in the cycle right after acceptance and offers a stray stop in the middle of a bit. For both, its per-clock reference model expects the running waveform to continue unchanged.

// File: rtl/i2ct_pkg.sv
// Shared types for the I2C bus timing generator.
// Assumes: opcodes 5..7 are treated as illegal by the sequencer.
package i2ct_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } op_e;

    // Latched timing configuration; div is log2 of the tick length.
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] slow;
        logic [1:0] div;
    } cfg_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK,
        ST_STA_HD,
        ST_LO_HD,
        ST_LO_SU,
        ST_BIT_HI,
        ST_RS_SUSTA,
        ST_RS_HDSTA,
        ST_SP_SUSTO,
        ST_SP_BUF
    } st_e;

endpackage

// File: rtl/i2ct_tick_gen.sv
// Base tick prescaler: one tick every 2**div clocks.
// Assumes: clear restarts the period so a phase starts on a whole tick.
module i2ct_tick_gen
    import i2ct_pkg::*;
#(
    parameter int PC_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] div,
    output logic       tick
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    // Decode the tick length into the last count value.
    always_comb begin
        case (div)
            2'd0:    lim = PC_W'(0);
            2'd1:    lim = PC_W'(1);
            default: lim = PC_W'(3);
        endcase
    end

    assign tick = (pc_q == lim);

    // Advance the prescaler, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) pc_q <= '0;
        else                         pc_q <= pc_q + PC_W'(1);
    end

    // R10
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= lim);

endmodule

// File: rtl/i2ct_phase_table.sv
// Phase length lookup: high, low and data-hold counts in ticks.
// Assumes: speed class 2 and 3 are the same fastest class.
module i2ct_phase_table
    import i2ct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  cfg_t             cfg,
    output logic [CNT_W-1:0] t_high,
    output logic [CNT_W-1:0] t_low,
    output logic [CNT_W-1:0] t_hold
);
    // Compute the three counts from speed class and slow-down column.
    always_comb begin
        case (cfg.mode)
            2'd0: begin
                t_high = CNT_W'(108 + 12 * int'(cfg.slow));
                t_low  = CNT_W'(132 + 12 * int'(cfg.slow));
                t_hold = CNT_W'(24);
            end
            2'd1: begin
                t_high = CNT_W'(24 + 3 * int'(cfg.slow));
                t_low  = CNT_W'(36 + 3 * int'(cfg.slow));
                t_hold = CNT_W'(12);
            end
            default: begin
                case (cfg.slow)
                    2'd0:    t_high = CNT_W'(10);
                    2'd1:    t_high = CNT_W'(11);
                    2'd2:    t_high = CNT_W'(13);
                    default: t_high = CNT_W'(14);
                endcase
                t_low  = CNT_W'(14 + int'(cfg.slow));
                t_hold = CNT_W'(4);
            end
        endcase
    end

    // R8
    always_comb begin
        low_gt_hold_chk: assert (t_low > t_hold);
    end

endmodule

// File: rtl/i2ct_phase_cnt.sv
// Phase timer: counts ticks of one phase and flags its last tick.
// Assumes: load_val is the phase length minus one.
module i2ct_phase_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             pend
);
    logic [CNT_W-1:0] cnt_q;

    assign pend = tick && (cnt_q == '0);

    // Load at phase entry, count down on ticks, rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (tick && cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
    end

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_bus_timer.sv
// I2C master bus timing generator: sequences start, repeated start,
// stop and single-bit phases on open-drain SCL/SDA enables.
// Assumes: one command at a time; timing inputs captured on acceptance.
module i2c_bus_timer
    import i2ct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_mode,
    input  logic [1:0] slow_code,
    input  logic [1:0] tick_sel,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_wbit,
    input  logic       sda_in,
    output logic       cmd_done,
    output logic       rd_bit,
    output logic       scl_pull_low,
    output logic       sda_pull_low,
    output logic       bus_busy
);
    st_e  st_q, st_n;
    op_e  op_q, op_n;
    cfg_t cfg_q, cfg_n, cfg_in, cfg_use;
    logic wb_q, wb_n, scl_q, scl_n, sda_q, sda_n;
    logic busy_q, busy_n, done_q, done_n, rd_q, rd_n;
    logic is_wait, accept, load, tick, pend;
    logic [CNT_W-1:0] len, t_high, t_low, t_hold;

    // Capture-ready configuration with the tick length clamp applied.
    always_comb begin
        cfg_in.mode = speed_mode;
        cfg_in.slow = slow_code;
        if (tick_sel == 2'd0)                         cfg_in.div = 2'd0;
        else if (tick_sel == 2'd1 || speed_mode != 0) cfg_in.div = 2'd1;
        else                                          cfg_in.div = 2'd2;
    end

    assign is_wait = (st_q == ST_IDLE) || (st_q == ST_PARK);
    assign accept  = cmd_valid && (
        (st_q == ST_IDLE && cmd_op == OP_START) ||
        (st_q == ST_PARK && cmd_op != OP_START && cmd_op <= OP_READ));
    assign cfg_use = is_wait ? cfg_in : cfg_q;

    i2ct_phase_table #(.CNT_W(CNT_W)) u_table (
        .cfg(cfg_use), .t_high(t_high), .t_low(t_low), .t_hold(t_hold));

    i2ct_tick_gen #(.PC_W(2)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(load), .div(cfg_q.div), .tick(tick));

    i2ct_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(len - CNT_W'(1)),
        .tick(tick), .pend(pend));

    // Next-state, line levels and phase length for each bus event.
    always_comb begin
        st_n = st_q;  op_n = op_q;  wb_n = wb_q;  cfg_n = cfg_q;
        scl_n = scl_q; sda_n = sda_q; busy_n = busy_q; rd_n = rd_q;
        done_n = 1'b0; load = 1'b0; len = t_high;
        case (st_q)
            ST_IDLE, ST_PARK: if (accept) begin
                cfg_n = cfg_in;
                op_n  = op_e'(cmd_op);
                wb_n  = cmd_wbit;
                load  = 1'b1;
                if (cmd_op == OP_START) begin
                    st_n = ST_STA_HD; sda_n = 1'b1; busy_n = 1'b1; len = t_high;
                end else begin
                    st_n = ST_LO_HD; len = t_hold;
                end
            end
            ST_STA_HD: if (pend) begin
                scl_n = 1'b1; done_n = 1'b1; st_n = ST_PARK;
            end
            ST_LO_HD: if (pend) begin
                st_n = ST_LO_SU; load = 1'b1; len = t_low - t_hold;
                case (op_q)
                    OP_WRITE: sda_n = ~wb_q;
                    OP_STOP:  sda_n = 1'b1;
                    default:  sda_n = 1'b0;
                endcase
            end
            ST_LO_SU: if (pend) begin
                scl_n = 1'b0; load = 1'b1;
                case (op_q)
                    OP_RESTART: begin st_n = ST_RS_SUSTA; len = t_low;  end
                    OP_STOP:    begin st_n = ST_SP_SUSTO; len = t_high; end
                    default:    begin st_n = ST_BIT_HI;   len = t_high; end
                endcase
            end
            ST_BIT_HI: if (pend) begin
                scl_n = 1'b1; done_n = 1'b1; st_n = ST_PARK;
                if (op_q == OP_READ) rd_n = sda_in;
            end
            ST_RS_SUSTA: if (pend) begin
                sda_n = 1'b1; load = 1'b1; len = t_high; st_n = ST_RS_HDSTA;
            end
            ST_RS_HDSTA: if (pend) begin
                scl_n = 1'b1; done_n = 1'b1; st_n = ST_PARK;
            end
            ST_SP_SUSTO: if (pend) begin
                sda_n = 1'b0; load = 1'b1; len = t_low; st_n = ST_SP_BUF;
            end
            ST_SP_BUF: if (pend) begin
                busy_n = 1'b0; done_n = 1'b1; st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Register sequencer state, line enables and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; op_q <= OP_START; wb_q <= 1'b0; cfg_q <= '0;
            scl_q <= 1'b0; sda_q <= 1'b0; busy_q <= 1'b0;
            done_q <= 1'b0; rd_q <= 1'b0;
        end else begin
            st_q <= st_n; op_q <= op_n; wb_q <= wb_n; cfg_q <= cfg_n;
            scl_q <= scl_n; sda_q <= sda_n; busy_q <= busy_n;
            done_q <= done_n; rd_q <= rd_n;
        end
    end

    assign scl_pull_low = scl_q;
    assign sda_pull_low = sda_q;
    assign bus_busy     = busy_q;
    assign cmd_done     = done_q;
    assign rd_bit       = rd_q;

    // R4
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT_HI) |=> (st_q != ST_BIT_HI) || $stable(sda_pull_low));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> (sda_pull_low && !scl_pull_low));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> (cmd_done && !scl_pull_low && !sda_pull_low));

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!bus_busy && !scl_pull_low && !sda_pull_low));

endmodule

// File: tb/i2c_bus_timer_tb.sv
`timescale 1ns/1ps
module i2c_bus_timer_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cmd_valid, cmd_wbit, slv;
    logic [1:0] speed_mode, slow_code, tick_sel;
    logic [2:0] cmd_op;
    logic cmd_done, rd_bit, scl_pull_low, sda_pull_low, bus_busy, sda_in;

    assign sda_in = ~sda_pull_low & slv;

    i2c_bus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .speed_mode(speed_mode), .slow_code(slow_code),
        .tick_sel(tick_sel), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wbit(cmd_wbit), .sda_in(sda_in), .cmd_done(cmd_done), .rd_bit(rd_bit),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low), .bus_busy(bus_busy));

    // Expected {scl, sda, busy, done, rd} for each coming cycle.
    logic [4:0] exp_q[$];
    string      tag_q[$];
    string      steady_tag;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit m_scl = 0, m_sda = 0, m_busy = 0, m_rd = 0;

    function automatic int f_hi(int md, int r);
        int fastest[4] = '{10, 11, 13, 14};
        if (md == 0) return 108 + 12 * r;
        if (md == 1) return 24 + 3 * r;
        return fastest[r];
    endfunction
    function automatic int f_lo(int md, int r);
        if (md == 0) return 132 + 12 * r;
        if (md == 1) return 36 + 3 * r;
        return 14 + r;
    endfunction
    function automatic int f_hd(int md);
        if (md == 0) return 24;
        if (md == 1) return 12;
        return 4;
    endfunction
    function automatic int f_m(int md, int sel);
        if (sel == 0) return 1;
        if (sel == 1) return 2;
        return (md == 0) ? 4 : 2;
    endfunction

    task automatic push(int n, bit s, bit d, bit b, bit dn, string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({s, d, b, dn, m_rd});
            tag_q.push_back(t);
        end
    endtask

    task automatic cmp();
        logic [4:0] e, a;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
        end else begin
            e = {m_scl, m_sda, m_busy, 1'b0, m_rd}; t = steady_tag;
        end
        a = {scl_pull_low, sda_pull_low, bus_busy, cmd_done, rd_bit};
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s at %0t: {scl,sda,busy,done,rd} actual %b expected %b",
                     t, $time, a, e);
        end
    endtask

    // Offer one command now; model its waveform; run until the queue drains.
    task automatic run(int op, bit wb, int md, int r, int sel, bit scramble,
                       int poke_at, string t);
        int m, hh, ll, dd;
        bit sv;
        speed_mode = 2'(md); slow_code = 2'(r); tick_sel = 2'(sel);
        cmd_op = 3'(op); cmd_wbit = wb; cmd_valid = 1'b1;
        m = f_m(md, sel); hh = f_hi(md, r) * m; ll = f_lo(md, r) * m; dd = f_hd(md) * m;
        if (op == 0 && !m_busy) begin
            push(hh, 0, 1, 1, 0, t);
            m_scl = 1; m_sda = 1; m_busy = 1;
            push(1, 1, 1, 1, 1, t);
        end else if (op >= 1 && op <= 4 && m_busy) begin
            sv = (op == 3) ? ~wb : (op == 2);
            push(dd, 1, m_sda, 1, 0, t);
            push(ll - dd, 1, sv, 1, 0, t);
            if (op == 1) begin
                push(ll, 0, 0, 1, 0, t);
                push(hh, 0, 1, 1, 0, t);
                m_scl = 1; m_sda = 1;
                push(1, 1, 1, 1, 1, t);
            end else if (op == 2) begin
                push(hh, 0, 1, 1, 0, t);
                push(ll, 0, 0, 1, 0, t);
                m_scl = 0; m_sda = 0; m_busy = 0;
                push(1, 0, 0, 0, 1, t);
            end else begin
                push(hh, 0, sv, 1, 0, t);
                if (op == 4) m_rd = slv;
                m_scl = 1; m_sda = sv;
                push(1, 1, sv, 1, 1, t);
            end
        end
        cmp();
        cmd_valid = 1'b0;
        if (scramble) begin
            speed_mode = ~speed_mode; slow_code = ~slow_code; tick_sel = 2'd1;
        end
        for (int k = 0; exp_q.size() > 0; k++) begin
            if (k == poke_at && exp_q.size() > 2) begin
                cmd_op = 3'd2; cmd_valid = 1'b1;
            end
            cmp();
            cmd_valid = 1'b0;
        end
    endtask

    task automatic idle_cmp(int n);
        for (int i = 0; i < n; i++) cmp();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_wbit = 0; slv = 1;
        speed_mode = 0; slow_code = 0; tick_sel = 0;
        steady_tag = "R1 reset state";
        repeat (3) @(posedge clk);
        idle_cmp(1);
        rst_n = 1;
        idle_cmp(4);

        // R3: non-start commands while the bus is free are ignored.
        steady_tag = "R3 ignored while idle";
        run(3, 0, 0, 0, 0, 0, -1, "R3");
        idle_cmp(20);
        run(2, 0, 0, 0, 0, 0, -1, "R3");
        run(1, 0, 0, 0, 0, 0, -1, "R3");
        idle_cmp(20);

        // Standard mode, no slow-down, tick of one clock.
        steady_tag = "R12 steady after done";
        run(0, 0, 0, 0, 0, 0, -1, "R2 start std R8");
        run(3, 0, 0, 0, 0, 0, -1, "R4 write0 std");
        run(3, 1, 0, 0, 0, 0, -1, "R4 write1 std");
        slv = 1; run(4, 0, 0, 0, 0, 0, -1, "R5 read1");
        slv = 0; run(4, 0, 0, 0, 0, 0, -1, "R5 read0");
        slv = 1;
        steady_tag = "R3 start while busy";
        run(0, 0, 0, 0, 0, 0, -1, "R3");
        idle_cmp(10);
        run(6, 0, 0, 0, 0, 0, -1, "R3 illegal op");
        idle_cmp(10);
        steady_tag = "R12 steady after done";
        run(1, 0, 0, 0, 0, 0, -1, "R6 restart std");
        run(3, 0, 0, 0, 0, 0, 50, "R12 write with stray stop");
        run(7, 0, 0, 0, 0, 0, -1, "R3 illegal op");
        run(2, 0, 0, 0, 0, 0, -1, "R7 stop std");
        idle_cmp(10);

        // R9 and R10: slowest column with a four-clock tick.
        run(0, 0, 0, 3, 2, 0, -1, "R9 R10 start std m4");
        run(3, 1, 0, 3, 2, 0, -1, "R9 R10 write std m4");
        run(2, 0, 0, 3, 2, 0, -1, "R9 R10 stop std m4");

        // Fast mode with a two-clock tick and the clamp of a four-clock request.
        run(0, 0, 1, 1, 1, 0, -1, "R8 R10 start fast");
        slv = 0; run(4, 0, 1, 1, 1, 0, -1, "R5 R8 read fast");
        slv = 1; run(2, 0, 1, 1, 1, 0, -1, "R8 stop fast");
        run(0, 0, 1, 2, 2, 0, -1, "R10 clamp start");
        run(3, 0, 1, 2, 2, 0, -1, "R10 clamp write");
        run(2, 0, 1, 2, 2, 0, -1, "R10 clamp stop");

        // Fastest class across all slow-down columns.
        for (int r = 0; r < 4; r++) begin
            run(0, 0, 2 + (r % 2), r, 0, 0, -1, "R8 R9 fastest start");
            run(3, r[0], 2, r, 0, 0, -1, "R8 R9 fastest write");
            run(1, 0, 3, r, 0, 0, -1, "R6 R9 fastest restart");
            run(2, 0, 2, r, 0, 0, -1, "R7 R9 fastest stop");
        end

        // R11: timing inputs change right after acceptance.
        run(0, 0, 0, 0, 0, 1, -1, "R11 start");
        run(3, 0, 0, 0, 0, 1, -1, "R11 write");
        run(2, 0, 0, 0, 0, 1, -1, "R11 stop");
        idle_cmp(10);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule